// File: doc/BRIEF.md
# Collision-Only Wait-State Memory Arbiter

This block lets a host read or write an emulation SRAM that a target is also reading. The host posts one command and the block holds it until it sees a target access finish. Then it cuts the SRAM off from the target-side buffers and runs a host cycle of fixed length. A target access is present when its chip-select and its strobe are both high. If a target access ends and another starts only after the host cycle is over, the target never notices the host.

When the target does start an access while the host cycle runs, the block pulls its active-low ready output low to insert wait states. Ready stays low for the rest of the host cycle and for a settle interval after the buffers reconnect. It then goes high, and the host is told the command is complete. If no target access ends within a bounded wait, the command is dropped with a timeout flag. If the target is in reset, the host is served without waiting. The ready output behaves the same whether or not the board routes it to the target.

Top module: `waitStateArbiter`

## Requirements
- R1: After reset, readyN is high, isolate is low, hostDone and hostTimeout are low and sramCe is low.
- R2: A command accepted by a one-cycle hostReq pulse stays pending, with isolate low, until a target access ends. A target access is tgtSel and tgtStrobe both high, and it ends in the first cycle where it is no longer present. The host cycle starts in the next cycle, and isolate is high for exactly HOST_CYCLES cycles.
- R3: During the host cycle, sramCe is high and sramAddr/sramWdata carry the command. sramWe is high in every host cycle for a write (hostWrite=1) and in none for a read. For a read, hostRdata holds the sramRdata sampled in the last host cycle.
- R4: If a target access is present during the host cycle while tgtRst is low, readyN goes low in that same cycle and stays low for the rest of the host cycle.
- R5: After a collision, readyN stays low for SETTLE_CYCLES more cycles with isolate already low.
- R6: hostDone is a one-cycle pulse in the first cycle after readyN is released. It comes HOST_CYCLES+1 cycles after the host cycle starts without a collision, and HOST_CYCLES+SETTLE_CYCLES+1 cycles after it with one.
- R7: With no target access during the host cycle, readyN stays high for the whole command.
- R8: If no target access ends within TIMEOUT_CYCLES pending cycles, hostTimeout pulses for one cycle. The command is dropped without any SRAM access, isolate stays low and no hostDone follows.
- R9: While tgtRst is high, a pending command starts its host cycle in the cycle after it was accepted, and readyN stays high even if tgtSel and tgtStrobe are high.
- R10: hostReq is ignored while a command is pending or in progress. It starts no second host cycle and does not change the address or data in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle command pulse, accepted only when idle |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostAddr | input | ADDR_W | Command address |
| hostWdata | input | DATA_W | Write data |
| hostRdata | output | DATA_W | Read data of the last read command |
| hostDone | output | 1 | Command completed (one cycle) |
| hostTimeout | output | 1 | Command dropped, no target access ended (one cycle) |
| tgtSel | input | 1 | Target chip-select, high active |
| tgtStrobe | input | 1 | Target access strobe, high active |
| tgtRst | input | 1 | Target held in reset, high active |
| readyN | output | 1 | Active-low wait request to the target |
| isolate | output | 1 | Disconnects target-side buffers from the SRAM |
| sramCe | output | 1 | SRAM enable for the host cycle |
| sramWe | output | 1 | SRAM write strobe |
| sramAddr | output | ADDR_W | SRAM address from the host |
| sramWdata | output | DATA_W | SRAM write data |
| sramRdata | input | DATA_W | SRAM read data |

## Verification
The critical overlap is between collision detection and the end of the host cycle. This happens when a target access begins in the first or the very last host cycle, so that the stall and the move to the settle phase are decided at the same edge. Directed runs raise the target strobe at both boundaries, and randomised runs place it anywhere in the host window. Each run is judged by counting the cycles readyN is low against HOST_CYCLES+SETTLE_CYCLES minus the collision offset, and by checking that hostDone lands exactly one cycle after the release.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_HOST,
    ST_SETTLE,
    ST_DONE,
    ST_TOUT
  } arbState_t;

  typedef struct packed {
    logic loadCmd;
    logic sramOn;
    logic capture;
    logic cntClr;
  } ctlStrobes_t;

endpackage

// File: rtl/arbTgtMonitor.sv
module arbTgtMonitor (
  input  logic clk,
  input  logic rstN,
  input  logic tgtSel,
  input  logic tgtStrobe,
  output logic tgtActive,
  output logic tgtEnd
);

  logic prevActive;

  assign tgtActive = tgtSel & tgtStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) prevActive <= 1'b0;
    else       prevActive <= tgtActive;
  end

  assign tgtEnd = prevActive & ~tgtActive;

endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
#(
  parameter int HOST_CYCLES    = 30,
  parameter int SETTLE_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 200,
  parameter int CNT_W          = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              tgtActive,
  input  logic              tgtEnd,
  input  logic              tgtRst,
  input  logic [CNT_W-1:0]  count,
  output ctlStrobes_t       ctl,
  output logic              hostDone,
  output logic              hostTimeout,
  output logic              readyN,
  output logic              isolate
);

  localparam logic [CNT_W-1:0] HOST_LAST   = CNT_W'(HOST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TOUT_LAST   = CNT_W'(TIMEOUT_CYCLES - 1);

  arbState_t state, nextState;
  logic      stalled;
  logic      collide;
  logic      hostLast;

  assign collide  = (state == ST_HOST) & tgtActive & ~tgtRst;
  assign hostLast = (state == ST_HOST) & (count == HOST_LAST);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (hostReq) nextState = ST_PEND;
      ST_PEND: begin
        if (tgtRst || tgtEnd)        nextState = ST_HOST;
        else if (count == TOUT_LAST) nextState = ST_TOUT;
      end
      ST_HOST:   if (hostLast) nextState = (stalled || collide) ? ST_SETTLE : ST_DONE;
      ST_SETTLE: if (count == SETTLE_LAST) nextState = ST_DONE;
      ST_DONE:   nextState = ST_IDLE;
      ST_TOUT:   nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stalled <= 1'b0;
    end else begin
      state <= nextState;
      if (state != ST_HOST) stalled <= 1'b0;
      else if (collide)     stalled <= 1'b1;
    end
  end

  always_comb begin
    ctl.loadCmd = (state == ST_IDLE) & hostReq;
    ctl.sramOn  = (state == ST_HOST);
    ctl.capture = hostLast;
    ctl.cntClr  = (nextState != state);
  end

  assign isolate     = (state == ST_HOST);
  assign readyN      = ~(((state == ST_HOST) & (stalled | collide)) | (state == ST_SETTLE));
  assign hostDone    = (state == ST_DONE);
  assign hostTimeout = (state == ST_TOUT);

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] sramRdata,
  output logic              sramCe,
  output logic              sramWe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic              wrReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReg    <= 1'b0;
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      count    <= '0;
    end else begin
      if (ctl.loadCmd) begin
        wrReg    <= hostWrite;
        addrReg  <= hostAddr;
        wdataReg <= hostWdata;
      end
      if (ctl.capture && !wrReg) rdataReg <= sramRdata;
      if (ctl.cntClr)            count <= '0;
      else if (count != CNT_TOP) count <= count + 1'b1;
    end
  end

  assign sramCe    = ctl.sramOn;
  assign sramWe    = ctl.sramOn & wrReg;
  assign sramAddr  = addrReg;
  assign sramWdata = wdataReg;
  assign hostRdata = rdataReg;

endmodule

// File: rtl/waitStateArbiter.sv
module waitStateArbiter
  import arbPkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 8,
  parameter int HOST_CYCLES    = 30,
  parameter int SETTLE_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic              hostTimeout,
  input  logic              tgtSel,
  input  logic              tgtStrobe,
  input  logic              tgtRst,
  output logic              readyN,
  output logic              isolate,
  output logic              sramCe,
  output logic              sramWe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdata,
  input  logic [DATA_W-1:0] sramRdata
);

  localparam int MAX_A = (HOST_CYCLES > SETTLE_CYCLES) ? HOST_CYCLES : SETTLE_CYCLES;
  localparam int MAX_C = (MAX_A > TIMEOUT_CYCLES) ? MAX_A : TIMEOUT_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctlStrobes_t      ctl;
  logic             tgtActive;
  logic             tgtEnd;
  logic [CNT_W-1:0] count;

  arbTgtMonitor u_mon (
    .clk       (clk),
    .rstN      (rstN),
    .tgtSel    (tgtSel),
    .tgtStrobe (tgtStrobe),
    .tgtActive (tgtActive),
    .tgtEnd    (tgtEnd)
  );

  arbControl #(
    .HOST_CYCLES    (HOST_CYCLES),
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .CNT_W          (CNT_W)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .hostReq     (hostReq),
    .tgtActive   (tgtActive),
    .tgtEnd      (tgtEnd),
    .tgtRst      (tgtRst),
    .count       (count),
    .ctl         (ctl),
    .hostDone    (hostDone),
    .hostTimeout (hostTimeout),
    .readyN      (readyN),
    .isolate     (isolate)
  );

  arbDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .sramRdata (sramRdata),
    .sramCe    (sramCe),
    .sramWe    (sramWe),
    .sramAddr  (sramAddr),
    .sramWdata (sramWdata),
    .hostRdata (hostRdata),
    .count     (count)
  );

endmodule

// File: rtl/arbChecker.sv
module arbChecker (
  input logic clk,
  input logic rstN,
  input logic hostDone,
  input logic hostTimeout,
  input logic tgtSel,
  input logic tgtStrobe,
  input logic tgtRst,
  input logic readyN,
  input logic isolate,
  input logic sramCe,
  input logic sramWe
);

  assert_we_inside_host_R3: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (sramCe && isolate));

  assert_stall_on_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> (isolate && tgtSel && tgtStrobe && !tgtRst));

  assert_settle_continues_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!readyN && !isolate) |-> $past(!readyN));

  assert_done_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> (readyN && !isolate));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostTimeout |-> (!sramCe && !isolate && !hostDone && readyN));

  assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostTimeout |=> !hostTimeout);

  assert_no_stall_in_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tgtRst && isolate) |-> readyN);

endmodule

bind waitStateArbiter arbChecker u_arbChecker (
  .clk         (clk),
  .rstN        (rstN),
  .hostDone    (hostDone),
  .hostTimeout (hostTimeout),
  .tgtSel      (tgtSel),
  .tgtStrobe   (tgtStrobe),
  .tgtRst      (tgtRst),
  .readyN      (readyN),
  .isolate     (isolate),
  .sramCe      (sramCe),
  .sramWe      (sramWe)
);

// File: tb/test_waitStateArbiter.sv
module test_waitStateArbiter;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int H  = 30;
  localparam int S  = 4;
  localparam int T  = 200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWrite = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic          hostDone, hostTimeout;
  logic          tgtSel = 1'b0, tgtStrobe = 1'b0, tgtRst = 1'b0;
  logic          readyN, isolate, sramCe, sramWe;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramWdata;
  logic [DW-1:0] sramRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rdFor(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 8'h5A;
  endfunction

  assign sramRdata = rdFor(sramAddr);

  waitStateArbiter i_waitStateArbiter (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostDone(hostDone), .hostTimeout(hostTimeout), .tgtSel(tgtSel),
    .tgtStrobe(tgtStrobe), .tgtRst(tgtRst), .readyN(readyN), .isolate(isolate),
    .sramCe(sramCe), .sramWe(sramWe), .sramAddr(sramAddr), .sramWdata(sramWdata),
    .sramRdata(sramRdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expDoneAt(input int colAt);
    return (colAt > 0) ? H + S + 1 : H + 1;
  endfunction

  function automatic int expLow(input int colAt);
    return (colAt > 0) ? H + S - colAt : 0;
  endfunction

  // colAt: host-cycle index (1..H) at which the target starts a new access, 0 = none
  // strayAt: host-cycle index at which a stray hostReq is pulsed, 0 = none
  task automatic runAccess(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int pre, input int colAt, input int strayAt);
    int k = 0, isoCnt = 0, firstIso = 0, lowCnt = 0, weCnt = 0, doneAt = 0, doneCnt = 0;
    bit addrOk = 1'b1, isoPend = 1'b0, readyAtDone = 1'b0;
    tgtSel = 1'b1; tgtStrobe = 1'b1;
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 1'b0;
    if (isolate) isoPend = 1'b1;
    for (int p = 0; p < pre; p++) begin
      @(negedge clk);
      if (isolate) isoPend = 1'b1;
    end
    tgtStrobe = 1'b0;
    while (doneAt == 0 && k < H + S + 8) begin
      @(negedge clk);
      k++;
      hostReq = 1'b0;
      if (isolate) begin
        isoCnt++;
        if (firstIso == 0) firstIso = k;
        if (sramAddr != a || (wr && sramWdata != d)) addrOk = 1'b0;
      end
      if (!readyN) lowCnt++;
      if (sramWe) weCnt++;
      if (hostDone) begin doneAt = k; readyAtDone = readyN; end
      if (k == colAt) tgtStrobe = 1'b1;
      if (k == strayAt) begin
        hostReq = 1'b1; hostAddr = ~a; hostWdata = ~d;
      end
    end
    tgtStrobe = 1'b0; tgtSel = 1'b0;
    for (int q = 0; q < 6; q++) begin
      @(negedge clk);
      if (hostDone || isolate) doneCnt++;
    end
    check(!isoPend, "R2 isolate while pending", isoPend, 0);
    check(firstIso == 1, "R2 host cycle start", firstIso, 1);
    check(isoCnt == H, "R2 host cycle length", isoCnt, H);
    check(weCnt == (wr ? H : 0), "R3 write strobe cycles", weCnt, wr ? H : 0);
    check(addrOk, "R3 SRAM address and data", addrOk, 1);
    if (!wr) check(hostRdata == rdFor(a), "R3 read data", hostRdata, rdFor(a));
    if (colAt > 0) check(lowCnt == expLow(colAt), "R4 R5 ready low cycles", lowCnt, expLow(colAt));
    else           check(lowCnt == 0, "R7 ready without collision", lowCnt, 0);
    check(doneAt == expDoneAt(colAt), "R6 done timing", doneAt, expDoneAt(colAt));
    check(readyAtDone, "R6 ready released at done", readyAtDone, 1);
    if (strayAt > 0) check(doneCnt == 0, "R10 stray request ignored", doneCnt, 0);
  endtask

  task automatic runTimeout(input bit holdActive);
    int m = 0, toAt = 0, toCnt = 0, bad = 0;
    tgtSel = holdActive; tgtStrobe = holdActive;
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 12'h123; hostWdata = 8'hC3;
    while (m < T + 10) begin
      @(negedge clk);
      m++;
      hostReq = 1'b0;
      if (hostTimeout) begin toCnt++; if (toAt == 0) toAt = m; end
      if (sramCe || isolate || hostDone || !readyN) bad++;
    end
    tgtSel = 1'b0; tgtStrobe = 1'b0;
    @(negedge clk);
    check(toAt == T + 1, "R8 timeout cycle", toAt, T + 1);
    check(toCnt == 1, "R8 timeout pulse count", toCnt, 1);
    check(bad == 0, "R8 no access after timeout", bad, 0);
  endtask

  task automatic runTgtReset();
    int m = 0, firstIso = 0, doneAt = 0, lowCnt = 0;
    tgtRst = 1'b1; tgtSel = 1'b1; tgtStrobe = 1'b1;
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 12'h0A5; hostWdata = '0;
    while (doneAt == 0 && m < H + 10) begin
      @(negedge clk);
      m++;
      hostReq = 1'b0;
      if (isolate && firstIso == 0) firstIso = m;
      if (!readyN) lowCnt++;
      if (hostDone) doneAt = m;
    end
    tgtRst = 1'b0; tgtSel = 1'b0; tgtStrobe = 1'b0;
    @(negedge clk);
    check(firstIso == 2, "R9 immediate grant in reset", firstIso, 2);
    check(lowCnt == 0, "R9 no stall in reset", lowCnt, 0);
    check(doneAt == H + 2, "R9 done in reset", doneAt, H + 2);
    check(hostRdata == rdFor(12'h0A5), "R9 read data in reset", hostRdata, rdFor(12'h0A5));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(readyN == 1'b1, "R1 readyN reset", readyN, 1);
    check(!isolate && !sramCe, "R1 isolate/sramCe reset", isolate, 0);
    check(!hostDone && !hostTimeout, "R1 done/timeout reset", hostDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(readyN && !isolate && !hostDone && !hostTimeout, "R1 idle after reset", readyN, 1);

    runAccess(1'b1, 12'h010, 8'h3C, 2, 0, 0);
    runAccess(1'b0, 12'h021, 8'h00, 0, 0, 0);
    runAccess(1'b0, 12'h0F3, 8'h00, 3, 1, 0);
    runAccess(1'b1, 12'h044, 8'hA5, 1, H, 0);
    runAccess(1'b1, 12'h055, 8'h66, 4, 0, 5);
    runAccess(1'b0, 12'h066, 8'h00, 1, 12, 7);
    runTimeout(1'b0);
    runTimeout(1'b1);
    runTgtReset();

    for (int n = 0; n < 30; n++) begin
      logic          wr = 1'($urandom_range(0, 1));
      logic [AW-1:0] a  = AW'($urandom);
      logic [DW-1:0] d  = DW'($urandom);
      int            pr = $urandom_range(0, 10);
      int            col = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, H);
      runAccess(wr, a, d, pr, col, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule